// File: doc/BRIEF.md
# Exception Entry Unit

This block performs the state update a processor needs when it takes an exception. Exception detection is done elsewhere. The detection logic presents an accept strobe together with a cause code, the program counter of the interrupted instruction, the current interrupt-enable bits, a normal handler base, a debug handler base and a remap control bit.

In the next clock cycle the block delivers four things:
- the handler address for the fetch unit;
- a one-cycle save request that puts the interrupted program counter into one of two return-address registers;
- an updated set of enable bits with a write strobe;
- an error flag when the cause code is not one it knows.

Causes fall into two classes. Ordinary causes are bus errors, divide by zero, interrupt and system call. Debug causes are breakpoint and watchpoint. The two classes use different return registers, different shadow bits and, unless remapped, different bases. The register file and the return-from-exception path are not part of this block.

Top module: `exc_entry`

## Requirements
- R1: Cause codes are: 1 breakpoint, 2 instruction bus error, 3 watchpoint, 4 data bus error, 5 divide by zero, 6 interrupt, 7 system call. Codes 1 and 3 are debug causes; codes 2, 4, 5, 6 and 7 are ordinary causes.
- R2: All outputs are registered. An accepted cause sampled at a rising edge while `take_i` is high produces its results after that edge. `npc_valid_o`, `ra_we_o`, `ie_we_o` and `err_o` are single-cycle pulses.
- R3: The handler address `npc_o` equals the selected base plus the cause code shifted left by 5 bits (32-byte vector spacing), with modulo 2^AW wraparound.
- R4: A debug cause always selects `base_dbg_i`.
- R5: An ordinary cause selects `base_norm_i` when `remap_i` is 0 and `base_dbg_i` when `remap_i` is 1.
- R6: On an accepted valid cause, `ra_we_o` pulses and `ra_data_o` carries the sampled `pc_i`. `ra_sel_o` is 0 to target the exception-address register (ordinary cause) or 1 to target the breakpoint-address register (debug cause).
- R7: Enable bits are laid out as bit 0 global enable, bit 1 exception shadow and bit 2 breakpoint shadow. On an accepted valid cause, `ie_o` has bit 0 cleared. For an ordinary cause, bit 1 is set to the old bit 0 and bit 2 is kept. For a debug cause, bit 2 is set to the old bit 0 and bit 1 is kept. `ie_we_o` pulses in the same cycle.
- R8: An accepted cause code of 0 (or any code above 7) raises `err_o` for one cycle. It raises no other strobe, and `npc_o`, `ra_data_o`, `ra_sel_o` and `ie_o` keep their previous values.
- R9: While `take_i` is low, no strobe rises and the data outputs hold their values.
- R10: A synchronous active-high `rst` clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| take_i | input | 1 | Accept strobe for an exception |
| cause_i | input | CAUSE_W | Cause code |
| pc_i | input | AW | Program counter of the interrupted instruction |
| ie_i | input | 3 | Current enable bits |
| remap_i | input | 1 | Redirect ordinary causes to the debug base |
| base_norm_i | input | AW | Normal handler base |
| base_dbg_i | input | AW | Debug handler base |
| npc_o | output | AW | Handler address |
| npc_valid_o | output | 1 | Handler address valid pulse |
| ra_we_o | output | 1 | Return-address save pulse |
| ra_sel_o | output | 1 | Return register select (0 exception, 1 breakpoint) |
| ra_data_o | output | AW | Saved program counter |
| ie_o | output | 3 | Updated enable bits |
| ie_we_o | output | 1 | Enable bits write pulse |
| err_o | output | 1 | Unknown cause pulse |

## Verification
The remap control and debug classification can act in the same cycle. In that case the classification must win, because a breakpoint or watchpoint keeps the debug base whatever the remap bit says. The bench provokes this with directed cases that raise `remap_i` together with codes 1 and 3. It then drives random mixes in which remap, cause and accept strobe change every cycle. Each handler address and shadow-bit update is compared with a model that picks the base from the class first and only then consults the remap bit.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int IE_W   = 3;
  localparam int IE_GIE = 0;
  localparam int IE_ESH = 1;
  localparam int IE_BSH = 2;

  localparam int C_BRK  = 1;
  localparam int C_IBUS = 2;
  localparam int C_WTCH = 3;
  localparam int C_DBUS = 4;
  localparam int C_DIV0 = 5;
  localparam int C_IRQ  = 6;
  localparam int C_SYS  = 7;

  typedef enum logic [1:0] {
    CLS_NONE   = 2'd0,
    CLS_NORMAL = 2'd1,
    CLS_DEBUG  = 2'd2
  } exc_cls_e;
endpackage

// File: rtl/exc_classify.sv
module exc_classify
  import exc_entry_pkg::*;
#(
  parameter int CAUSE_W = 3
) (
  input  logic [CAUSE_W-1:0] cause_i,
  output exc_cls_e           cls_o
);
  always_comb begin
    unique case (int'(cause_i))
      C_BRK, C_WTCH:                       cls_o = CLS_DEBUG;
      C_IBUS, C_DBUS, C_DIV0, C_IRQ, C_SYS: cls_o = CLS_NORMAL;
      default:                             cls_o = CLS_NONE;
    endcase
  end
endmodule

// File: rtl/exc_vector.sv
module exc_vector
  import exc_entry_pkg::*;
#(
  parameter int AW       = 32,
  parameter int CAUSE_W  = 3,
  parameter int VEC_SH   = 5,
  parameter bit REMAP_EN = 1'b1
) (
  input  exc_cls_e           cls_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic               remap_i,
  input  logic [AW-1:0]      base_norm_i,
  input  logic [AW-1:0]      base_dbg_i,
  output logic [AW-1:0]      vec_o
);
  logic          use_dbg;
  logic [AW-1:0] base_sel;
  logic [AW-1:0] offset;

  generate
    if (REMAP_EN) begin : g_remap
      assign use_dbg = (cls_i == CLS_DEBUG) || remap_i;
    end else begin : g_noremap
      logic unused_remap;
      assign unused_remap = remap_i;
      assign use_dbg = (cls_i == CLS_DEBUG);
    end
  endgenerate

  assign base_sel = use_dbg ? base_dbg_i : base_norm_i;
  assign offset   = AW'(cause_i) << VEC_SH;
  assign vec_o    = base_sel + offset;
endmodule

// File: rtl/exc_ie_update.sv
module exc_ie_update
  import exc_entry_pkg::*;
(
  input  exc_cls_e        cls_i,
  input  logic [IE_W-1:0] ie_i,
  output logic [IE_W-1:0] ie_o
);
  always_comb begin
    ie_o = ie_i;
    ie_o[IE_GIE] = 1'b0;
    if (cls_i == CLS_DEBUG) ie_o[IE_BSH] = ie_i[IE_GIE];
    else                    ie_o[IE_ESH] = ie_i[IE_GIE];
  end
endmodule

// File: rtl/exc_entry.sv
module exc_entry
  import exc_entry_pkg::*;
#(
  parameter int AW       = 32,
  parameter int CAUSE_W  = 3,
  parameter int VEC_SH   = 5,
  parameter bit REMAP_EN = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               take_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [AW-1:0]      pc_i,
  input  logic [IE_W-1:0]    ie_i,
  input  logic               remap_i,
  input  logic [AW-1:0]      base_norm_i,
  input  logic [AW-1:0]      base_dbg_i,
  output logic [AW-1:0]      npc_o,
  output logic               npc_valid_o,
  output logic               ra_we_o,
  output logic               ra_sel_o,
  output logic [AW-1:0]      ra_data_o,
  output logic [IE_W-1:0]    ie_o,
  output logic               ie_we_o,
  output logic               err_o
);
  exc_cls_e        cls;
  logic [AW-1:0]   vec;
  logic [IE_W-1:0] ie_next;
  logic            acc_ok;
  logic            acc_bad;

  exc_classify #(.CAUSE_W(CAUSE_W)) u_cls (
    .cause_i (cause_i),
    .cls_o   (cls)
  );

  exc_vector #(
    .AW(AW), .CAUSE_W(CAUSE_W), .VEC_SH(VEC_SH), .REMAP_EN(REMAP_EN)
  ) u_vec (
    .cls_i       (cls),
    .cause_i     (cause_i),
    .remap_i     (remap_i),
    .base_norm_i (base_norm_i),
    .base_dbg_i  (base_dbg_i),
    .vec_o       (vec)
  );

  exc_ie_update u_ie (
    .cls_i (cls),
    .ie_i  (ie_i),
    .ie_o  (ie_next)
  );

  assign acc_ok  = take_i && (cls != CLS_NONE);
  assign acc_bad = take_i && (cls == CLS_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      npc_o       <= '0;
      npc_valid_o <= 1'b0;
      ra_we_o     <= 1'b0;
      ra_sel_o    <= 1'b0;
      ra_data_o   <= '0;
      ie_o        <= '0;
      ie_we_o     <= 1'b0;
      err_o       <= 1'b0;
    end else begin
      npc_valid_o <= acc_ok;
      ra_we_o     <= acc_ok;
      ie_we_o     <= acc_ok;
      err_o       <= acc_bad;
      if (acc_ok) begin
        npc_o     <= vec;
        ra_sel_o  <= (cls == CLS_DEBUG);
        ra_data_o <= pc_i;
        ie_o      <= ie_next;
      end
    end
  end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          take_i,
  input logic [AW-1:0] pc_i,
  input logic          npc_valid_o,
  input logic          ra_we_o,
  input logic          ie_we_o,
  input logic          err_o,
  input logic [AW-1:0] ra_data_o,
  input logic [2:0]    ie_o
);
  // R6, R7: save and enable writes travel with the handler address
  a_r6_strobes_together: assert property (@(posedge clk) disable iff (rst)
    npc_valid_o |-> (ra_we_o && ie_we_o));
  // R6: saved value is the program counter sampled with the strobe
  a_r6_saved_pc: assert property (@(posedge clk) disable iff (rst)
    $rose(ra_we_o) |-> (ra_data_o == $past(pc_i)));
  // R7: global enable is clear after entry
  a_r7_gie_clear: assert property (@(posedge clk) disable iff (rst)
    ie_we_o |-> !ie_o[0]);
  // R8: error and normal entry exclude each other
  a_r8_err_excl: assert property (@(posedge clk) disable iff (rst)
    $onehot0({err_o, npc_valid_o}));
  // R9: no strobe without an accept in the previous cycle
  a_r9_no_take_quiet: assert property (@(posedge clk) disable iff (rst)
    !take_i |=> !(npc_valid_o || err_o));
endmodule

bind exc_entry exc_entry_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .take_i      (take_i),
  .pc_i        (pc_i),
  .npc_valid_o (npc_valid_o),
  .ra_we_o     (ra_we_o),
  .ie_we_o     (ie_we_o),
  .err_o       (err_o),
  .ra_data_o   (ra_data_o),
  .ie_o        (ie_o)
);

// File: tb/exc_entry_bench.sv
module exc_entry_bench;
  localparam int AW = 32;
  localparam int CW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          take_i = 1'b0;
  logic [CW-1:0] cause_i = '0;
  logic [AW-1:0] pc_i = '0;
  logic [2:0]    ie_i = '0;
  logic          remap_i = 1'b0;
  logic [AW-1:0] base_norm_i = '0;
  logic [AW-1:0] base_dbg_i = '0;
  logic [AW-1:0] npc_o;
  logic          npc_valid_o, ra_we_o, ra_sel_o, ie_we_o, err_o;
  logic [AW-1:0] ra_data_o;
  logic [2:0]    ie_o;

  int checks = 0;
  int errors = 0;

  // expected state
  logic [AW-1:0] e_npc = '0, e_ra = '0;
  logic          e_sel = 1'b0;
  logic [2:0]    e_ie = '0;
  logic          e_ok = 1'b0, e_bad = 1'b0;

  always #5 clk = ~clk;

  exc_entry #(.AW(AW), .CAUSE_W(CW)) u_exc_entry (
    .clk(clk), .rst(rst), .take_i(take_i), .cause_i(cause_i), .pc_i(pc_i),
    .ie_i(ie_i), .remap_i(remap_i), .base_norm_i(base_norm_i),
    .base_dbg_i(base_dbg_i), .npc_o(npc_o), .npc_valid_o(npc_valid_o),
    .ra_we_o(ra_we_o), .ra_sel_o(ra_sel_o), .ra_data_o(ra_data_o),
    .ie_o(ie_o), .ie_we_o(ie_we_o), .err_o(err_o)
  );

  function automatic bit is_dbg(input logic [CW-1:0] c);
    return (c == 3'd1) || (c == 3'd3);
  endfunction

  function automatic bit is_known(input logic [CW-1:0] c);
    return c != 3'd0;
  endfunction

  function automatic logic [AW-1:0] exp_vec(input logic [CW-1:0] c, input logic rm,
                                            input logic [AW-1:0] bn, input logic [AW-1:0] bd);
    logic [AW-1:0] b;
    b = (is_dbg(c) || rm) ? bd : bn;
    return b + (AW'(c) * 32);
  endfunction

  function automatic logic [2:0] exp_ie(input logic [CW-1:0] c, input logic [2:0] ie);
    logic [2:0] r;
    r = ie;
    r[0] = 1'b0;
    if (is_dbg(c)) r[2] = ie[0];
    else           r[1] = ie[0];
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [AW-1:0] act,
                       input logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    check(npc_valid_o == e_ok, {tag, " R2 npc_valid"}, AW'(npc_valid_o), AW'(e_ok));
    check(ra_we_o == e_ok, {tag, " R6 ra_we"}, AW'(ra_we_o), AW'(e_ok));
    check(ie_we_o == e_ok, {tag, " R7 ie_we"}, AW'(ie_we_o), AW'(e_ok));
    check(err_o == e_bad, {tag, " R8 err"}, AW'(err_o), AW'(e_bad));
    check(npc_o == e_npc, {tag, " R3 npc"}, npc_o, e_npc);
    check(ra_data_o == e_ra, {tag, " R6 ra_data"}, ra_data_o, e_ra);
    check(ra_sel_o == e_sel, {tag, " R6 ra_sel"}, AW'(ra_sel_o), AW'(e_sel));
    check(ie_o == e_ie, {tag, " R7 ie"}, AW'(ie_o), AW'(e_ie));
  endtask

  // drive one cycle at the falling edge, check after the next rising edge
  task automatic step(input logic tk, input logic [CW-1:0] c, input logic [AW-1:0] pc,
                      input logic [2:0] ie, input logic rm, input logic [AW-1:0] bn,
                      input logic [AW-1:0] bd, input string tag);
    @(negedge clk);
    take_i = tk; cause_i = c; pc_i = pc; ie_i = ie; remap_i = rm;
    base_norm_i = bn; base_dbg_i = bd;
    e_ok  = tk && is_known(c);
    e_bad = tk && !is_known(c);
    if (e_ok) begin
      e_npc = exp_vec(c, rm, bn, bd);
      e_ra  = pc;
      e_sel = is_dbg(c);
      e_ie  = exp_ie(c, ie);
    end
    @(posedge clk);
    #2;
    compare_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #2;
    compare_all("R10 reset");
    @(negedge clk);
    rst = 1'b0;

    // R1, R4, R5: each cause, remap off and on
    for (int c = 0; c < 8; c++) begin
      step(1'b1, CW'(c), 32'h1000_0000 + c, 3'b001, 1'b0, 32'h0000_8000, 32'h0004_0000, "R1 R5 remap0");
      step(1'b1, CW'(c), 32'h2000_0000 + c, 3'b001, 1'b1, 32'h0000_8000, 32'h0004_0000, "R4 R5 remap1");
    end
    // R4: debug with remap set, enable clear -> shadow copies 0
    step(1'b1, 3'd1, 32'hDEAD_BEE0, 3'b110, 1'b1, 32'h0000_0100, 32'h0000_0F00, "R4 R7 brk remap");
    step(1'b1, 3'd3, 32'hDEAD_BEE4, 3'b011, 1'b0, 32'h0000_0100, 32'h0000_0F00, "R4 R7 wtch");
    // R3: wraparound
    step(1'b1, 3'd7, 32'h0000_0004, 3'b001, 1'b0, 32'hFFFF_FFF0, 32'h0, "R3 wrap");
    // R8: undefined cause holds previous data
    step(1'b1, 3'd0, 32'h5555_5555, 3'b111, 1'b1, 32'h1, 32'h2, "R8 undef");
    // R9: idle cycles hold
    step(1'b0, 3'd6, 32'h7777_7777, 3'b111, 1'b0, 32'h3, 32'h4, "R9 idle");
    step(1'b0, 3'd1, 32'h8888_8888, 3'b000, 1'b1, 32'h5, 32'h6, "R9 idle");

    // random mix
    for (int i = 0; i < 600; i++) begin
      step(($urandom % 4) != 0, CW'($urandom % 8), $urandom, 3'($urandom % 8),
           1'($urandom % 2), $urandom & 32'hFFFF_FF00, $urandom & 32'hFFFF_FF00, "rand");
    end

    // R10: reset mid-run clears outputs
    @(negedge clk);
    rst = 1'b1; take_i = 1'b1; cause_i = 3'd6;
    @(posedge clk);
    #2;
    e_ok = 1'b0; e_bad = 1'b0; e_npc = '0; e_ra = '0; e_sel = 1'b0; e_ie = '0;
    compare_all("R10 rerst");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule